// File: doc/BRIEF.md
# Serial Character Formatter with Bit Inversion and Order Select

This block is the data path of an asynchronous or smart-card serial link. On the transmit side it takes an 8-bit register byte through a valid/ready handshake and turns it into a line frame. The frame is a low start bit, seven or eight data bits, an optional parity bit and one or two high stop bits. On the receive side it collects the same frame format from the line and hands the register byte up with a one-cycle strobe. A parity-error pulse goes with that strobe when the received parity is wrong.

A small control byte selects the frame options. Data bits can be inverted and can travel least- or most-significant first, so the same logic serves both direct-convention and inverse-convention cards. Parity is always taken from the levels actually present on the line, and the parity bit itself is never inverted.

Bit timing comes from an external one-cycle `bit_tick` pulse. The transmitter moves the line at each tick, and the receiver samples `rx_line` at each tick. Everything runs on one clock with an active-high synchronous reset.

Top module: `sfmt_top`

## Requirements
- R1: After reset, `cfg_rdata` reads 8'h04, `tx_line` is 1, `tx_ready` is 1 and `rx_valid` is 0.
- R2: Control byte encoding is: bit0 invert, bit1 MSB-first, bit2 reserved, bit3 smart-card enable, bit4 seven-bit character, bit5 parity enable, bit6 odd parity, bit7 two stop bits. Bit2 always reads 1 whatever is written. Every other bit reads back the last written value.
- R3: A byte is accepted in a cycle where both `tx_valid` and `tx_ready` are high, and `tx_ready` drops in the next cycle. At each later tick the line takes the next frame bit: start 0, then the data bits, then parity if enabled, then one or two stop 1s. Between ticks the line holds its level. `tx_ready` and an idle-high line return at the first tick after the last stop bit.
- R4: With bit1 = 0, line data bit i (in time order) carries register bit i.
- R5: With bit1 = 1, line data bit i carries register bit 7-i. With a seven-bit character, MSB-first drops register bit 0 and LSB-first drops register bit 7.
- R6: With bit0 = 1, every transmitted data bit is the complement of its register bit. The parity bit is not complemented. In even mode the parity bit is the XOR of the line data levels, and in odd mode it is the complement of that XOR.
- R7: Received line bits are mapped back to the register with the same ordering and inversion. In seven-bit mode the unused register bit (bit 0 for MSB-first, bit 7 for LSB-first) reads 0.
- R8: `rx_valid` is a one-cycle pulse. It is high in the cycle after the tick that samples the last data bit, or the parity bit when parity is enabled. It is low at every other time.
- R9: `rx_perr` is high together with `rx_valid` exactly when the sampled parity level differs from the parity computed over the received line data levels.
- R10: With bit3 = 1, the frame uses eight data bits and even parity, whatever bits 4, 5 and 6 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle bit-period pulse |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write value |
| cfg_rdata | output | 8 | Control byte readback |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit register byte |
| tx_ready | output | 1 | Transmitter idle, can accept |
| tx_line | output | 1 | Serial output line |
| rx_line | input | 1 | Serial input line |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received register byte |
| rx_perr | output | 1 | Parity error pulse |

## Verification
The bench builds the block with its default package constants: an eight-bit register and a twelve-bit frame ceiling. These defaults make every real frame shape reachable. That includes the longest frame, with eight data bits, parity and two stop bits, and both seven-bit drop cases. The directed scenarios combine inversion with odd parity, MSB-first ordering with seven-bit characters, and the smart-card override. The last of these is written with seven-bit and odd-parity bits set. Injected parity faults are seen through the error pulse.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

    localparam int REG_W     = 8;
    localparam int STOP_MAX  = 2;
    localparam int FRAME_MAX = 1 + REG_W + 1 + STOP_MAX;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);
    localparam int IDX_W     = $clog2(REG_W);

    // control byte bit positions
    localparam int B_INV   = 0;
    localparam int B_MSB   = 1;
    localparam int B_RSV   = 2;
    localparam int B_SC    = 3;
    localparam int B_LEN7  = 4;
    localparam int B_PEN   = 5;
    localparam int B_ODD   = 6;
    localparam int B_STOP2 = 7;

    typedef struct packed {
        logic inv;
        logic msb;
        logic sc;
        logic len7;
        logic par_en;
        logic odd;
        logic stop2;
    } cfg_t;

    function automatic cfg_t cfg_unpack(input logic [REG_W-1:0] b);
        cfg_t c;
        c.inv    = b[B_INV];
        c.msb    = b[B_MSB];
        c.sc     = b[B_SC];
        c.len7   = b[B_LEN7];
        c.par_en = b[B_PEN];
        c.odd    = b[B_ODD];
        c.stop2  = b[B_STOP2];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
        logic [REG_W-1:0] b;
        b          = '0;
        b[B_INV]   = c.inv;
        b[B_MSB]   = c.msb;
        b[B_RSV]   = 1'b1;
        b[B_SC]    = c.sc;
        b[B_LEN7]  = c.len7;
        b[B_PEN]   = c.par_en;
        b[B_ODD]   = c.odd;
        b[B_STOP2] = c.stop2;
        return b;
    endfunction

    // smart-card mode overrides length and parity choices
    function automatic cfg_t cfg_effective(input cfg_t c);
        cfg_t e;
        e = c;
        if (c.sc) begin
            e.len7   = 1'b0;
            e.par_en = 1'b1;
            e.odd    = 1'b0;
        end
        return e;
    endfunction

    function automatic int char_bits(input cfg_t c);
        return c.len7 ? REG_W - 1 : REG_W;
    endfunction

    // register byte -> line data bits in time order (index 0 sent first)
    function automatic logic [REG_W-1:0] to_line(input logic [REG_W-1:0] d, input cfg_t c);
        logic [REG_W-1:0] o;
        int n;
        n = char_bits(c);
        o = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < n) o[i] = (c.msb ? d[REG_W-1-i] : d[i]) ^ c.inv;
        end
        return o;
    endfunction

    // line data bits in time order -> register byte
    function automatic logic [REG_W-1:0] from_line(input logic [REG_W-1:0] r, input cfg_t c);
        logic [REG_W-1:0] o;
        int n;
        n = char_bits(c);
        o = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < n) begin
                if (c.msb) o[REG_W-1-i] = r[i] ^ c.inv;
                else       o[i]         = r[i] ^ c.inv;
            end
        end
        return o;
    endfunction

endpackage

// File: rtl/sfmt_ctl.sv
module sfmt_ctl
    import sfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg,
    output logic [REG_W-1:0] rdata
);

    typedef struct packed {
        cfg_t raw;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) st_d.raw = cfg_unpack(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg   = cfg_effective(st_q.raw);
    assign rdata = cfg_pack(st_q.raw);

endmodule

// File: rtl/sfmt_tx.sv
module sfmt_tx
    import sfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  cfg_t             cfg,
    input  logic             tx_valid,
    input  logic [REG_W-1:0] tx_data,
    output logic             tx_ready,
    output logic             tx_line
);

    typedef struct packed {
        logic                 busy;
        logic                 line;
        logic [FRAME_MAX-1:0] sh;
        logic [CNT_W-1:0]     cnt;
    } tx_st_t;

    tx_st_t st_d, st_q;

    logic [REG_W-1:0]     line_bits;
    logic                 par_bit;
    logic [FRAME_MAX-1:0] frame;
    int                   nbits;
    int                   flen;

    always_comb begin
        nbits     = char_bits(cfg);
        line_bits = to_line(tx_data, cfg);
        par_bit   = (^line_bits) ^ cfg.odd;
        frame     = '1;
        frame[0]  = 1'b0;
        for (int i = 0; i < REG_W; i++) begin
            if (i < nbits) frame[1+i] = line_bits[i];
        end
        if (cfg.par_en) frame[1+nbits] = par_bit;
        flen = 2 + nbits + int'(cfg.par_en) + int'(cfg.stop2);

        st_d = st_q;
        if (!st_q.busy && tx_valid) begin
            st_d.busy = 1'b1;
            st_d.sh   = frame;
            st_d.cnt  = CNT_W'(flen);
        end else if (st_q.busy && bit_tick) begin
            if (st_q.cnt != '0) begin
                st_d.line = st_q.sh[0];
                st_d.sh   = {1'b1, st_q.sh[FRAME_MAX-1:1]};
                st_d.cnt  = st_q.cnt - 1'b1;
            end else begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            st_q.line <= 1'b1;
            st_q.sh   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ready = !st_q.busy;
    assign tx_line  = st_q.line;

endmodule

// File: rtl/sfmt_rx.sv
module sfmt_rx
    import sfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_tick,
    input  cfg_t             cfg,
    input  logic             rx_line,
    output logic             rx_valid,
    output logic [REG_W-1:0] rx_data,
    output logic             rx_perr
);

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_DATA = 2'd1,
        RX_PAR  = 2'd2
    } rx_ph_t;

    typedef struct packed {
        rx_ph_t           ph;
        cfg_t             cfg;
        logic [REG_W-1:0] sh;
        logic [IDX_W-1:0] idx;
        logic             valid;
        logic             perr;
        logic [REG_W-1:0] data;
    } rx_st_t;

    rx_st_t st_d, st_q;
    int     nbits;

    always_comb begin
        nbits    = char_bits(st_q.cfg);
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.perr  = 1'b0;
        if (bit_tick) begin
            unique case (st_q.ph)
                RX_IDLE: begin
                    if (!rx_line) begin
                        st_d.ph  = RX_DATA;
                        st_d.idx = '0;
                        st_d.sh  = '0;
                        st_d.cfg = cfg;
                    end
                end
                RX_DATA: begin
                    st_d.sh[st_q.idx] = rx_line;
                    if (st_q.idx == IDX_W'(nbits - 1)) begin
                        if (st_q.cfg.par_en) begin
                            st_d.ph = RX_PAR;
                        end else begin
                            st_d.ph    = RX_IDLE;
                            st_d.valid = 1'b1;
                            st_d.data  = from_line(st_d.sh, st_q.cfg);
                        end
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end
                RX_PAR: begin
                    st_d.ph    = RX_IDLE;
                    st_d.valid = 1'b1;
                    st_d.data  = from_line(st_q.sh, st_q.cfg);
                    st_d.perr  = rx_line ^ (^st_q.sh) ^ st_q.cfg.odd;
                end
                default: st_d.ph = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rx_valid = st_q.valid;
    assign rx_data  = st_q.data;
    assign rx_perr  = st_q.perr;

endmodule

// File: rtl/sfmt_top.sv
module sfmt_top
    import sfmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       tx_line,
    input  logic       rx_line,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_perr
);

    cfg_t cfg;

    sfmt_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg),
        .rdata (cfg_rdata)
    );

    sfmt_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .cfg      (cfg),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .tx_line  (tx_line)
    );

    sfmt_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .cfg      (cfg),
        .rx_line  (rx_line),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .rx_perr  (rx_perr)
    );

endmodule

// File: rtl/sfmt_chk.sv
module sfmt_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_tick,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic       tx_line,
    input logic       rx_valid,
    input logic       rx_perr,
    input logic [7:0] cfg_rdata
);

    assert_rsv_one_R2: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[2] == 1'b1);

    assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
        tx_ready |-> tx_line);

    assert_line_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(tx_line));

    assert_ready_drop_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_ready) |-> $past(tx_valid));

    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_perr_with_valid_R9: assert property (@(posedge clk) disable iff (rst)
        rx_perr |-> rx_valid);

endmodule

bind sfmt_top sfmt_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_line   (tx_line),
    .rx_valid  (rx_valid),
    .rx_perr   (rx_perr),
    .cfg_rdata (cfg_rdata)
);

// File: tb/sim_sfmt_top.sv
module sim_sfmt_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_ready;
    logic       tx_line;
    logic       rx_line = 1'b1;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_perr;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    sfmt_top u0 (
        .clk       (clk),
        .rst       (rst),
        .bit_tick  (bit_tick),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_ready  (tx_ready),
        .tx_line   (tx_line),
        .rx_line   (rx_line),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_perr   (rx_perr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // frame model built from the requirement text
    task automatic model(input logic [7:0] d, input logic [7:0] c,
                         output logic [11:0] f, output int len, output int last);
        bit sc, pen, odd, p, b;
        int n;
        sc  = c[3];
        n   = (c[4] && !sc) ? 7 : 8;
        pen = c[5] || sc;
        odd = c[6] && !sc;
        f   = 12'hFFF;
        f[0] = 1'b0;
        p   = odd;
        for (int i = 0; i < n; i++) begin
            b = c[1] ? d[7-i] : d[i];
            b = b ^ c[0];
            f[1+i] = b;
            p = p ^ b;
        end
        if (pen) f[1+n] = p;
        len  = 2 + n + int'(pen) + int'(c[7]);
        last = n + int'(pen);
    endtask

    task automatic t_reset;
        chk(cfg_rdata == 8'h04, "R1", "cfg after reset", cfg_rdata, 8'h04);
        chk(tx_line == 1'b1, "R1", "line after reset", tx_line, 1);
        chk(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
        chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    endtask

    task automatic t_reserved;
        wr_cfg(8'h00);
        chk(cfg_rdata == 8'h04, "R2", "reserved after write 00", cfg_rdata, 8'h04);
        wr_cfg(8'hFB);
        chk(cfg_rdata == 8'hFF, "R2", "readback after write FB", cfg_rdata, 8'hFF);
        wr_cfg(8'h6A);
        chk(cfg_rdata == 8'h6E, "R2", "readback after write 6A", cfg_rdata, 8'h6E);
    endtask

    task automatic tx_case(input logic [7:0] c, input logic [7:0] d, input string req);
        logic [11:0] f, got;
        int len, last;
        model(d, c, f, len, last);
        wr_cfg(c);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data  = d;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R3", "ready after accept", tx_ready, 0);
        got = 12'hFFF;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            got[k] = tx_line;
            @(negedge clk);
        end
        chk(got == f, req, "tx frame bits", got, f);
        chk(tx_ready == 1'b0, "R3", "ready during last stop", tx_ready, 0);
        @(negedge clk);
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        chk(tx_ready == 1'b1 && tx_line == 1'b1, "R3", "idle after frame",
            {tx_ready, tx_line}, 2'b11);
    endtask

    task automatic rx_case(input logic [7:0] c, input logic [7:0] d, input bit flip,
                           input logic [7:0] expd, input string req);
        logic [11:0] f;
        int len, last, early;
        model(d, c, f, len, last);
        if (flip) f[last] = ~f[last];
        wr_cfg(c);
        early = 0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            rx_line  = f[k];
            bit_tick = 1'b1;
            @(negedge clk);
            bit_tick = 1'b0;
            if (k < last && rx_valid) early++;
            if (k == last) begin
                chk(rx_valid == 1'b1, "R8", "valid after last bit", rx_valid, 1);
                chk(rx_data == expd, req, "rx data", rx_data, expd);
                chk(rx_perr == flip, "R9", "parity error flag", rx_perr, flip);
            end
            if (k == last + 1) begin
                chk(rx_valid == 1'b0, "R8", "valid cleared at stop", rx_valid, 0);
            end
        end
        chk(early == 0, "R8", "no early valid", early, 0);
        rx_line = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reserved();
        tx_case(8'h20, 8'hA5, "R4");
        tx_case(8'h22, 8'h1E, "R5");
        tx_case(8'h32, 8'h81, "R5");
        tx_case(8'h10, 8'h80, "R5");
        tx_case(8'h61, 8'h3C, "R6");
        tx_case(8'h23, 8'h5A, "R6");
        tx_case(8'h58, 8'hC3, "R10");
        tx_case(8'hA0, 8'h55, "R3");
        rx_case(8'h20, 8'hA5, 1'b0, 8'hA5, "R7");
        rx_case(8'h32, 8'h81, 1'b0, 8'h80, "R7");
        rx_case(8'h10, 8'hFF, 1'b0, 8'h7F, "R7");
        rx_case(8'h61, 8'h3C, 1'b1, 8'h3C, "R9");
        rx_case(8'h23, 8'h5A, 1'b0, 8'h5A, "R6");
        rx_case(8'h58, 8'hC3, 1'b1, 8'hC3, "R10");
        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        total++;
        bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule